// File: doc/BRIEF.md
# Exception Cause Dispatch Unit

This block takes exception requests from a processor pipeline and updates the exception part of the processor state. A request carries the program counter of the faulting instruction, a 6-bit cause code and, when the fault concerns memory, the faulting virtual address. From the exception-mode and user-mode status bits the block picks the target vector (kernel, user or double) and writes the exception PC, the double-exception PC, the cause, the virtual-address register and the exception-mode bit.

A second request source reports misaligned loads and stores. A build-time rule decides whether such an access becomes an alignment exception. The exception registers also have a plain write port, so that a handler can restore or clear them. Their current values are always present on output ports.

The vector select and a one-cycle "taken" strobe are registered and appear in the cycle after the request. A build-time option chooses whether a double exception saves its PC in a dedicated register or in the level-1 exception PC.

Top module: `exc_dispatch`

## Requirements
- R1: A request accepted while the exception-mode bit is set produces vector code 2 (double) in the next cycle.
- R2: For a double exception the PC is written into the double-exception PC register when HAS_DEPC is 1 and the level-1 PC is left unchanged. When HAS_DEPC is 0 the PC goes into the level-1 PC, and the double-exception PC reads 0 and ignores writes.
- R3: A request accepted while exception mode is clear writes the level-1 PC and selects vector code 1 (user) if the user-mode bit is set, and vector code 0 (kernel) if it is clear.
- R4: Every accepted exception writes its cause code into the cause register and sets the exception-mode bit. The user-mode bit is left as it was.
- R5: The virtual-address register is written with the request address only when the request carries an address. Otherwise it keeps its value.
- R6: The taken strobe is high for exactly the cycle after an accepted exception. The vector select changes only together with taken and holds its value otherwise.
- R7: A misaligned-access report becomes an exception with cause 9 and the access address only when UNALIGNED_EXC is 1 and HW_ALIGN is 0. A report that arrives in the same cycle as an explicit request is dropped, and the explicit request is taken.
- R8: The register write port addresses status at 0 (bit 0 exception mode, bit 1 user mode), level-1 PC at 1, double-exception PC at 2, cause at 3 (low 6 bits) and virtual address at 4. Writes to addresses 5 to 7 change nothing.
- R9: A register write in the same cycle as an accepted exception is dropped.
- R10: After reset every register, the vector select and the taken strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Explicit exception request pulse |
| req_pc | input | PC_W | PC of the faulting instruction |
| req_cause | input | CAUSE_W | Cause code |
| req_has_addr | input | 1 | Request carries a faulting address |
| req_addr | input | PC_W | Faulting virtual address |
| mis_valid | input | 1 | Misaligned load/store report |
| mis_pc | input | PC_W | PC of the misaligned access |
| mis_addr | input | PC_W | Misaligned address |
| sw_we | input | 1 | Register write enable |
| sw_addr | input | 3 | Register write index |
| sw_wdata | input | PC_W | Register write data |
| vec_sel_o | output | 2 | Vector select: 0 kernel, 1 user, 2 double |
| taken_o | output | 1 | Exception taken strobe |
| excm_o | output | 1 | Exception-mode status bit |
| um_o | output | 1 | User-mode status bit |
| epc_o | output | PC_W | Level-1 exception PC |
| depc_o | output | PC_W | Double-exception PC |
| cause_o | output | CAUSE_W | Exception cause |
| vaddr_o | output | PC_W | Exception virtual address |

## Verification
The assertions check on every cycle that a request made in exception mode yields a taken double vector, that a request made in user or kernel state yields the matching vector, that the cause lands and exception mode is set, that an address-less request leaves the virtual-address register untouched, that a write colliding with an exception loses, and that the vector holds between exceptions. Only the bench scenarios can show the build-time variants: the PC register chosen when no double-exception PC exists, and the suppressed alignment rule. They also cover the ignored write addresses and the agreement of every register with a reference model over long random mixes of requests, reports and writes.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2
    } vec_e;

    typedef enum logic [REG_AW-1:0] {
        REG_STATUS = 3'd0,
        REG_EPC    = 3'd1,
        REG_DEPC   = 3'd2,
        REG_CAUSE  = 3'd3,
        REG_VADDR  = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/exc_align_rule.sv
module exc_align_rule #(
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0
) (
    input  logic mis_valid,
    output logic raise
);
    generate
        if (UNALIGNED_EXC && !HW_ALIGN) begin : g_trap
            assign raise = mis_valid;
        end else begin : g_quiet
            logic unused_mis;
            assign unused_mis = mis_valid;
            assign raise = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/exc_req_arb.sv
module exc_req_arb #(
    parameter int PC_W        = 32,
    parameter int CAUSE_W     = 6,
    parameter int ALIGN_CAUSE = 9
) (
    input  logic               req_valid,
    input  logic [PC_W-1:0]    req_pc,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic               req_has_addr,
    input  logic [PC_W-1:0]    req_addr,
    input  logic               mis_raise,
    input  logic [PC_W-1:0]    mis_pc,
    input  logic [PC_W-1:0]    mis_addr,
    output logic               exc_valid,
    output logic [PC_W-1:0]    exc_pc,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               exc_has_addr,
    output logic [PC_W-1:0]    exc_addr
);
    localparam logic [CAUSE_W-1:0] ALIGN_CODE = CAUSE_W'(ALIGN_CAUSE);

    always_comb begin
        exc_valid    = req_valid | mis_raise;
        exc_pc       = req_pc;
        exc_cause    = req_cause;
        exc_has_addr = req_has_addr;
        exc_addr     = req_addr;
        if (!req_valid) begin
            exc_pc       = mis_pc;
            exc_cause    = ALIGN_CODE;
            exc_has_addr = 1'b1;
            exc_addr     = mis_addr;
        end
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
(
    input  logic excm,
    input  logic um,
    output vec_e vec
);
    always_comb begin
        if (excm)    vec = VEC_DOUBLE;
        else if (um) vec = VEC_USER;
        else         vec = VEC_KERNEL;
    end
endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int CAUSE_W  = 6,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [PC_W-1:0]    exc_pc,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_has_addr,
    input  logic [PC_W-1:0]    exc_addr,
    input  vec_e               vec,
    input  logic               sw_we,
    input  logic [REG_AW-1:0]  sw_addr,
    input  logic [PC_W-1:0]    sw_wdata,
    output logic [1:0]         vec_sel_o,
    output logic               taken_o,
    output logic               excm_o,
    output logic               um_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [PC_W-1:0]    depc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [PC_W-1:0]    vaddr_o
);
    typedef struct packed {
        logic               excm;
        logic               um;
        logic [PC_W-1:0]    epc;
        logic [PC_W-1:0]    depc;
        logic [PC_W-1:0]    vaddr;
        logic [CAUSE_W-1:0] cause;
        logic [1:0]         vec;
        logic               taken;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (exc_valid) begin
            if (exc_has_addr) st_d.vaddr = exc_addr;
            if (st_q.excm && HAS_DEPC) st_d.depc = exc_pc;
            else                       st_d.epc  = exc_pc;
            st_d.vec   = vec;
            st_d.cause = exc_cause;
            st_d.excm  = 1'b1;
            st_d.taken = 1'b1;
        end else if (sw_we) begin
            case (sw_addr)
                REG_STATUS: begin
                    st_d.excm = sw_wdata[0];
                    st_d.um   = sw_wdata[1];
                end
                REG_EPC:   st_d.epc   = sw_wdata;
                REG_DEPC:  st_d.depc  = sw_wdata;
                REG_CAUSE: st_d.cause = sw_wdata[CAUSE_W-1:0];
                REG_VADDR: st_d.vaddr = sw_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (HAS_DEPC) begin : g_depc
            assign depc_o = st_q.depc;
        end else begin : g_no_depc
            logic [PC_W-1:0] unused_depc;
            assign unused_depc = st_q.depc;
            assign depc_o      = '0;
        end
    endgenerate

    assign vec_sel_o = st_q.vec;
    assign taken_o   = st_q.taken;
    assign excm_o    = st_q.excm;
    assign um_o      = st_q.um;
    assign epc_o     = st_q.epc;
    assign cause_o   = st_q.cause;
    assign vaddr_o   = st_q.vaddr;
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int PC_W          = 32,
    parameter int CAUSE_W       = 6,
    parameter int ALIGN_CAUSE   = 9,
    parameter bit HAS_DEPC      = 1'b1,
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PC_W-1:0]    req_pc,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic               req_has_addr,
    input  logic [PC_W-1:0]    req_addr,
    input  logic               mis_valid,
    input  logic [PC_W-1:0]    mis_pc,
    input  logic [PC_W-1:0]    mis_addr,
    input  logic               sw_we,
    input  logic [2:0]         sw_addr,
    input  logic [PC_W-1:0]    sw_wdata,
    output logic [1:0]         vec_sel_o,
    output logic               taken_o,
    output logic               excm_o,
    output logic               um_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [PC_W-1:0]    depc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [PC_W-1:0]    vaddr_o
);
    logic               mis_raise;
    logic               exc_valid;
    logic [PC_W-1:0]    exc_pc;
    logic [CAUSE_W-1:0] exc_cause;
    logic               exc_has_addr;
    logic [PC_W-1:0]    exc_addr;
    vec_e               vec;

    exc_align_rule #(
        .UNALIGNED_EXC (UNALIGNED_EXC),
        .HW_ALIGN      (HW_ALIGN)
    ) u_align (
        .mis_valid (mis_valid),
        .raise     (mis_raise)
    );

    exc_req_arb #(
        .PC_W        (PC_W),
        .CAUSE_W     (CAUSE_W),
        .ALIGN_CAUSE (ALIGN_CAUSE)
    ) u_arb (
        .req_valid    (req_valid),
        .req_pc       (req_pc),
        .req_cause    (req_cause),
        .req_has_addr (req_has_addr),
        .req_addr     (req_addr),
        .mis_raise    (mis_raise),
        .mis_pc       (mis_pc),
        .mis_addr     (mis_addr),
        .exc_valid    (exc_valid),
        .exc_pc       (exc_pc),
        .exc_cause    (exc_cause),
        .exc_has_addr (exc_has_addr),
        .exc_addr     (exc_addr)
    );

    exc_vector_sel u_vsel (
        .excm (excm_o),
        .um   (um_o),
        .vec  (vec)
    );

    exc_state #(
        .PC_W     (PC_W),
        .CAUSE_W  (CAUSE_W),
        .HAS_DEPC (HAS_DEPC)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_valid    (exc_valid),
        .exc_pc       (exc_pc),
        .exc_cause    (exc_cause),
        .exc_has_addr (exc_has_addr),
        .exc_addr     (exc_addr),
        .vec          (vec),
        .sw_we        (sw_we),
        .sw_addr      (sw_addr),
        .sw_wdata     (sw_wdata),
        .vec_sel_o    (vec_sel_o),
        .taken_o      (taken_o),
        .excm_o       (excm_o),
        .um_o         (um_o),
        .epc_o        (epc_o),
        .depc_o       (depc_o),
        .cause_o      (cause_o),
        .vaddr_o      (vaddr_o)
    );
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [CAUSE_W-1:0] req_cause,
    input logic               req_has_addr,
    input logic               sw_we,
    input logic [2:0]         sw_addr,
    input logic [1:0]         vec_sel_o,
    input logic               taken_o,
    input logic               excm_o,
    input logic               um_o,
    input logic [PC_W-1:0]    vaddr_o,
    input logic [CAUSE_W-1:0] cause_o
);
    p_double_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && excm_o |=> taken_o && vec_sel_o == 2'd2);

    p_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !excm_o && um_o |=> vec_sel_o == 2'd1);

    p_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !excm_o && !um_o |=> vec_sel_o == 2'd0);

    p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> excm_o && cause_o == $past(req_cause));

    p_keep_um_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> um_o == $past(um_o));

    p_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_has_addr |=> $stable(vaddr_o));

    p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> $stable(vec_sel_o));

    p_write_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && sw_we && sw_addr == 3'd0 |=> excm_o);
endmodule

bind exc_dispatch exc_dispatch_chk #(
    .PC_W    (PC_W),
    .CAUSE_W (CAUSE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cause    (req_cause),
    .req_has_addr (req_has_addr),
    .sw_we        (sw_we),
    .sw_addr      (sw_addr),
    .vec_sel_o    (vec_sel_o),
    .taken_o      (taken_o),
    .excm_o       (excm_o),
    .um_o         (um_o),
    .vaddr_o      (vaddr_o),
    .cause_o      (cause_o)
);

// File: tb/tb_exc_dispatch.sv
`timescale 1ns/1ps
module tb_exc_dispatch;
    localparam int NDUT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [5:0]  req_cause = '0;
    logic        req_has_addr = 1'b0;
    logic [31:0] req_addr = '0;
    logic        mis_valid = 1'b0;
    logic [31:0] mis_pc = '0;
    logic [31:0] mis_addr = '0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;

    logic [1:0]  o_vec   [NDUT];
    logic        o_taken [NDUT];
    logic        o_excm  [NDUT];
    logic        o_um    [NDUT];
    logic [31:0] o_epc   [NDUT];
    logic [31:0] o_depc  [NDUT];
    logic [5:0]  o_cause [NDUT];
    logic [31:0] o_vaddr [NDUT];

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    // 0: dedicated double PC, alignment trap on
    // 1: no dedicated double PC
    // 2: hardware alignment, misaligned reports never trap
    exc_dispatch #(.HAS_DEPC(1'b1), .UNALIGNED_EXC(1'b1), .HW_ALIGN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_cause(req_cause), .req_has_addr(req_has_addr), .req_addr(req_addr),
        .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_addr(mis_addr),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .vec_sel_o(o_vec[0]), .taken_o(o_taken[0]), .excm_o(o_excm[0]), .um_o(o_um[0]),
        .epc_o(o_epc[0]), .depc_o(o_depc[0]), .cause_o(o_cause[0]), .vaddr_o(o_vaddr[0]));

    exc_dispatch #(.HAS_DEPC(1'b0), .UNALIGNED_EXC(1'b1), .HW_ALIGN(1'b0)) dut_nd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_cause(req_cause), .req_has_addr(req_has_addr), .req_addr(req_addr),
        .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_addr(mis_addr),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .vec_sel_o(o_vec[1]), .taken_o(o_taken[1]), .excm_o(o_excm[1]), .um_o(o_um[1]),
        .epc_o(o_epc[1]), .depc_o(o_depc[1]), .cause_o(o_cause[1]), .vaddr_o(o_vaddr[1]));

    exc_dispatch #(.HAS_DEPC(1'b1), .UNALIGNED_EXC(1'b1), .HW_ALIGN(1'b1)) dut_hw (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_cause(req_cause), .req_has_addr(req_has_addr), .req_addr(req_addr),
        .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_addr(mis_addr),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .vec_sel_o(o_vec[2]), .taken_o(o_taken[2]), .excm_o(o_excm[2]), .um_o(o_um[2]),
        .epc_o(o_epc[2]), .depc_o(o_depc[2]), .cause_o(o_cause[2]), .vaddr_o(o_vaddr[2]));

    typedef struct {
        bit        excm;
        bit        um;
        bit [31:0] epc;
        bit [31:0] depc;
        bit [31:0] vaddr;
        bit [5:0]  cause;
        bit [1:0]  vec;
        bit        taken;
    } mdl_t;

    mdl_t mdl [NDUT];
    bit   cfg_depc [NDUT] = '{1'b1, 1'b0, 1'b1};
    bit   cfg_trap [NDUT] = '{1'b1, 1'b1, 1'b0};

    function automatic mdl_t step(mdl_t s, bit has_depc, bit trap);
        mdl_t      n = s;
        bit        exc = 1'b0;
        bit [31:0] pc = '0;
        bit [31:0] a = '0;
        bit [5:0]  c = '0;
        bit        ha = 1'b0;
        n.taken = 1'b0;
        if (req_valid) begin
            exc = 1'b1; pc = req_pc; c = req_cause; ha = req_has_addr; a = req_addr;
        end else if (mis_valid && trap) begin
            exc = 1'b1; pc = mis_pc; c = 6'd9; ha = 1'b1; a = mis_addr;
        end
        if (exc) begin
            if (ha) n.vaddr = a;
            if (s.excm) begin
                n.vec = 2'd2;
                if (has_depc) n.depc = pc;
                else          n.epc  = pc;
            end else begin
                n.epc = pc;
                n.vec = s.um ? 2'd1 : 2'd0;
            end
            n.cause = c;
            n.excm  = 1'b1;
            n.taken = 1'b1;
        end else if (sw_we) begin
            case (sw_addr)
                3'd0: begin n.excm = sw_wdata[0]; n.um = sw_wdata[1]; end
                3'd1: n.epc = sw_wdata;
                3'd2: if (has_depc) n.depc = sw_wdata;
                3'd3: n.cause = sw_wdata[5:0];
                3'd4: n.vaddr = sw_wdata;
                default: ;
            endcase
        end
        return n;
    endfunction

    task automatic chk(input string tag, input string what, input int idx,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s dut%0d %s actual=%h expected=%h at %0t",
                     tag, idx, what, act, exp, $time);
        end
    endtask

    function automatic string pick(string t, string dflt);
        return (t == "") ? dflt : t;
    endfunction

    task automatic compare_all(input string t);
        for (int i = 0; i < NDUT; i++) begin
            chk(pick(t, "R6"), "taken", i, 32'(o_taken[i]), 32'(mdl[i].taken));
            chk(pick(t, "R6"), "vec",   i, 32'(o_vec[i]),   32'(mdl[i].vec));
            chk(pick(t, "R4"), "excm",  i, 32'(o_excm[i]),  32'(mdl[i].excm));
            chk(pick(t, "R4"), "um",    i, 32'(o_um[i]),    32'(mdl[i].um));
            chk(pick(t, "R3"), "epc",   i, o_epc[i],        mdl[i].epc);
            chk(pick(t, "R2"), "depc",  i, o_depc[i],       mdl[i].depc);
            chk(pick(t, "R4"), "cause", i, 32'(o_cause[i]), 32'(mdl[i].cause));
            chk(pick(t, "R5"), "vaddr", i, o_vaddr[i],      mdl[i].vaddr);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; mis_valid = 1'b0; sw_we = 1'b0;
    endtask

    // inputs are set after a falling edge; models advance at the rising edge;
    // outputs are compared at the next falling edge
    task automatic tick(input string t);
        @(posedge clk);
        for (int i = 0; i < NDUT; i++) mdl[i] = step(mdl[i], cfg_depc[i], cfg_trap[i]);
        @(negedge clk);
        compare_all(t);
        idle_inputs();
    endtask

    task automatic do_req(input logic [31:0] pc, input logic [5:0] c,
                          input logic ha, input logic [31:0] a);
        req_valid = 1'b1; req_pc = pc; req_cause = c; req_has_addr = ha; req_addr = a;
    endtask

    task automatic do_wr(input logic [2:0] ad, input logic [31:0] d);
        sw_we = 1'b1; sw_addr = ad; sw_wdata = d;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_0417));
        for (int i = 0; i < NDUT; i++) mdl[i] = '{default: '0};
        repeat (3) @(negedge clk);
        // R10: reset values
        compare_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R10");

        // R8: status write sets user mode (bit 1)
        do_wr(3'd0, 32'h2);
        tick("R8");
        // R3: user vector, level-1 PC, address captured
        do_req(32'h0000_1000, 6'd3, 1'b1, 32'hdead_beef);
        tick("R3");
        // R1: second request while in exception mode is a double
        do_req(32'h0000_2000, 6'd5, 1'b0, 32'h1111_1111);
        tick("R1");
        chk("R1", "vec", 0, 32'(o_vec[0]), 32'd2);
        chk("R2", "depc", 0, o_depc[0], 32'h0000_2000);
        chk("R2", "epc_nd", 1, o_epc[1], 32'h0000_2000);
        // R8: writes to unused indices change nothing
        do_wr(3'd5, 32'hffff_ffff); tick("R8");
        do_wr(3'd7, 32'hffff_ffff); tick("R8");
        do_wr(3'd2, 32'h0000_abcd); tick("R2");
        // R9: write colliding with an exception is dropped
        do_wr(3'd0, 32'h0);
        do_req(32'h0000_3000, 6'd7, 1'b0, 32'h0);
        tick("R9");
        chk("R9", "excm", 0, 32'(o_excm[0]), 32'd1);
        // back to kernel state, then a misaligned access
        do_wr(3'd0, 32'h0); tick("R8");
        mis_valid = 1'b1; mis_pc = 32'h0000_4000; mis_addr = 32'h0000_0103;
        tick("R7");
        chk("R7", "cause", 0, 32'(o_cause[0]), 32'd9);
        chk("R7", "taken_hw", 2, 32'(o_taken[2]), 32'd0);
        // R7: explicit request wins over a simultaneous report
        do_wr(3'd0, 32'h0); tick("R8");
        mis_valid = 1'b1; mis_pc = 32'h0000_5000; mis_addr = 32'h0000_0207;
        do_req(32'h0000_6000, 6'd12, 1'b0, 32'h0);
        tick("R7");
        chk("R7", "cause", 0, 32'(o_cause[0]), 32'd12);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 25) do_req($urandom, 6'($urandom), 1'($urandom), $urandom);
            r = int'($urandom_range(0, 99));
            if (r < 25) begin
                mis_valid = 1'b1; mis_pc = $urandom; mis_addr = $urandom;
            end
            r = int'($urandom_range(0, 99));
            if (r < 35) do_wr(3'($urandom), $urandom);
            tick("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule